// File: doc/BRIEF.md
# Tournament Branch Direction Predictor with Speculative Global History

This block predicts the direction of conditional branches by combining two component predictors. An address-indexed table of 2-bit saturating counters gives the first opinion, called the bimodal opinion. A second table of 2-bit counters gives the second opinion, called the gshare opinion. Its index is the global branch history XOR the low address bits. A third table of 2-bit counters picks, for each branch address, which component to trust. The component that has been right more often wins.

The prediction port is combinational. It returns the final direction, both component opinions and a checkpoint, which is the history value the prediction was made with. When the predict strobe is raised, the history register shifts in the predicted direction at the next clock edge. Counters are never trained at that point.

Later the pipeline resolves the branch and returns the address, the real direction, the checkpoint, the two component opinions and the final prediction that was used. The counters are trained at that time. If the final prediction was wrong, the history is rebuilt from the checkpoint with the real direction appended.

Top module: `tourn_predictor`

## Requirements
- R1: After reset the history register is zero, every bimodal and gshare counter holds weakly taken (2'b10) and every chooser counter holds 2'b01. As a result the first predictions are taken for both components and the chooser selects the gshare opinion.
- R2: Each table uses its own index. The bimodal index is address bits [9:0]. The gshare index is the 12-bit history XOR address bits [11:0]. The chooser index is address bits [9:0]. Addresses that differ only above these bits share an entry.
- R3: On a resolve, the bimodal counter and the gshare counter each step by one. They step up when the branch was taken, saturating at 2'b11, and down when it was not taken, saturating at 2'b00. A component opinion is the MSB of its counter (1 = taken).
- R4: The chooser works as follows. When its counter MSB is 1, the final prediction is the bimodal opinion; when it is 0, the final prediction is the gshare opinion. On a resolve where the bimodal opinion was right and the gshare opinion wrong, the counter steps up. In the reverse case it steps down. When both opinions were right, or both wrong, it is unchanged. It saturates at 2'b00 and 2'b11.
- R5: pred_ckpt always shows the current history. A cycle with pred_valid high (and no restore) shifts the history left by one, with the predicted direction entering bit 0.
- R6: A resolve whose res_pred differs from res_taken is a misprediction. It sets the history to {res_ckpt[10:0], res_taken}. A resolve with res_pred equal to res_taken leaves the history unchanged.
- R7: A restore and a speculative shift in the same cycle: the restore wins and the shift is dropped.
- R8: Predictions never change any counter. Gshare training uses the index built from res_ckpt, not from the current history.
- R9: With neither strobe high, the history holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_valid | input | 1 | Commit the current prediction into the history |
| pred_addr | input | 32 | Address of the branch being predicted |
| pred_taken | output | 1 | Final predicted direction |
| pred_bim | output | 1 | Bimodal component opinion |
| pred_gsh | output | 1 | Gshare component opinion |
| pred_ckpt | output | 12 | History used for this prediction (checkpoint) |
| res_valid | input | 1 | A branch resolves this cycle |
| res_addr | input | 32 | Address of the resolving branch |
| res_taken | input | 1 | Real direction |
| res_ckpt | input | 12 | Checkpoint returned at prediction time |
| res_bim | input | 1 | Bimodal opinion given at prediction time |
| res_gsh | input | 1 | Gshare opinion given at prediction time |
| res_pred | input | 1 | Final prediction given at prediction time |

## Verification
The assertions check the history register on every cycle: the one-bit speculative shift, the rebuild from the checkpoint on a misprediction, and holding when idle. They also check that each counter update moves the written entry by at most one step in the trained direction, and that the final prediction always equals one of the two component opinions. Several things only the directed scenarios can show. These are the exact index mapping and aliasing, the chooser policy when the components agree or disagree in correctness, saturation at both ends, the use of the checkpoint rather than the live history for gshare training, and the priority of a restore over a same-cycle shift.

// File: rtl/tp_pkg.sv
package tp_pkg;
   typedef logic [1:0] ctr_t;

   localparam ctr_t CTR_SNT = 2'b00;
   localparam ctr_t CTR_WNT = 2'b01;
   localparam ctr_t CTR_WT  = 2'b10;
   localparam ctr_t CTR_ST  = 2'b11;

   // one saturating step of a 2-bit counter
   function automatic ctr_t sat_next(input ctr_t c, input logic up);
      if (up) return (c == CTR_ST) ? c : ctr_t'(c + 2'd1);
      else    return (c == CTR_SNT) ? c : ctr_t'(c - 2'd1);
   endfunction
endpackage

// File: rtl/tp_ctr_array.sv
module tp_ctr_array
   import tp_pkg::*;
#(
   parameter int   IDX_W = 10,
   parameter ctr_t INIT  = CTR_WT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output ctr_t             rd_ctr,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic             upd_up
);
   localparam int DEPTH = 1 << IDX_W;

   if (IDX_W < 1 || IDX_W > 14) begin : g_bad_depth
      $error("tp_ctr_array: IDX_W out of range");
   end

   ctr_t mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
      end else if (upd_en) begin
         mem[upd_idx] <= sat_next(mem[upd_idx], upd_up);
      end
   end

   assign rd_ctr = mem[rd_idx];

   // checker state: remembers the last write to compare the entry afterwards
   logic             chk_vld;
   logic [IDX_W-1:0] chk_idx;
   ctr_t             chk_old;
   logic             chk_up;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_vld <= 1'b0;
         chk_idx <= '0;
         chk_old <= INIT;
         chk_up  <= 1'b0;
      end else begin
         chk_vld <= upd_en;
         chk_idx <= upd_idx;
         chk_old <= mem[upd_idx];
         chk_up  <= upd_up;
      end
   end

   // R3 / R4: an upward update never lowers the entry and moves it one step at most
   assert_train_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      chk_vld && chk_up |->
         (mem[chk_idx] >= chk_old) && ({1'b0, mem[chk_idx]} <= {1'b0, chk_old} + 3'd1));

   // R3 / R4: a downward update never raises the entry and moves it one step at most
   assert_train_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      chk_vld && !chk_up |->
         (mem[chk_idx] <= chk_old) && ({1'b0, chk_old} <= {1'b0, mem[chk_idx]} + 3'd1));
endmodule

// File: rtl/tp_index.sv
module tp_index #(
   parameter int ADDR_W  = 32,
   parameter int HIST_W  = 12,
   parameter int BIM_W   = 10,
   parameter int CH_W    = 10,
   parameter bit CH_HASH = 1'b0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [HIST_W-1:0] hist,
   output logic [BIM_W-1:0]  bim_idx,
   output logic [HIST_W-1:0] gsh_idx,
   output logic [CH_W-1:0]   ch_idx
);
   logic unused_addr_bits;
   assign unused_addr_bits = ^addr;

   assign bim_idx = addr[BIM_W-1:0];
   assign gsh_idx = hist ^ addr[HIST_W-1:0];

   if (CH_HASH) begin : g_ch_hashed
      assign ch_idx = addr[CH_W-1:0] ^ hist[CH_W-1:0];
   end else begin : g_ch_plain
      assign ch_idx = addr[CH_W-1:0];
   end
endmodule

// File: rtl/tp_hist.sv
module tp_hist #(
   parameter int HIST_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spec_en,
   input  logic              spec_dir,
   input  logic              fix_en,
   input  logic [HIST_W-1:0] fix_ckpt,
   input  logic              fix_dir,
   output logic [HIST_W-1:0] hist
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hist <= '0;
      else if (fix_en)  hist <= {fix_ckpt[HIST_W-2:0], fix_dir};
      else if (spec_en) hist <= {hist[HIST_W-2:0], spec_dir};
   end

   // R6 and R7: a misprediction rebuilds from the checkpoint, whatever the predict strobe
   assert_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fix_en |=> hist == {$past(fix_ckpt[HIST_W-2:0]), $past(fix_dir)});

   // R5: speculative shift by exactly one position
   assert_spec_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
      spec_en && !fix_en |=>
         (hist[HIST_W-1:1] == $past(hist[HIST_W-2:0])) && (hist[0] == $past(spec_dir)));

   // R9: idle cycles keep the history
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !spec_en && !fix_en |=> $stable(hist));
endmodule

// File: rtl/tourn_predictor.sv
module tourn_predictor
   import tp_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int HIST_W  = 12,
   parameter int BIM_W   = 10,
   parameter int CH_W    = 10,
   parameter bit CH_HASH = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pred_valid,
   input  logic [ADDR_W-1:0] pred_addr,
   output logic              pred_taken,
   output logic              pred_bim,
   output logic              pred_gsh,
   output logic [HIST_W-1:0] pred_ckpt,
   input  logic              res_valid,
   input  logic [ADDR_W-1:0] res_addr,
   input  logic              res_taken,
   input  logic [HIST_W-1:0] res_ckpt,
   input  logic              res_bim,
   input  logic              res_gsh,
   input  logic              res_pred
);
   if (HIST_W < 2 || HIST_W > ADDR_W) begin : g_bad_hist
      $error("tourn_predictor: HIST_W must lie in 2..ADDR_W");
   end
   if (BIM_W > ADDR_W || CH_W > ADDR_W) begin : g_bad_idx
      $error("tourn_predictor: index wider than address");
   end
   if (CH_HASH && CH_W > HIST_W) begin : g_bad_hash
      $error("tourn_predictor: hashed chooser needs CH_W <= HIST_W");
   end

   logic [HIST_W-1:0] hist;
   logic [BIM_W-1:0]  p_bim_idx, r_bim_idx;
   logic [HIST_W-1:0] p_gsh_idx, r_gsh_idx;
   logic [CH_W-1:0]   p_ch_idx,  r_ch_idx;
   ctr_t              bim_ctr, gsh_ctr, ch_ctr;

   // predict side indices use the live history
   tp_index #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .BIM_W(BIM_W), .CH_W(CH_W), .CH_HASH(CH_HASH))
   u_pidx (.addr(pred_addr), .hist(hist),
           .bim_idx(p_bim_idx), .gsh_idx(p_gsh_idx), .ch_idx(p_ch_idx));

   // resolve side indices use the returned checkpoint
   tp_index #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .BIM_W(BIM_W), .CH_W(CH_W), .CH_HASH(CH_HASH))
   u_ridx (.addr(res_addr), .hist(res_ckpt),
           .bim_idx(r_bim_idx), .gsh_idx(r_gsh_idx), .ch_idx(r_ch_idx));

   logic bim_ok, gsh_ok, ch_upd, mispredict;
   assign bim_ok     = (res_bim == res_taken);
   assign gsh_ok     = (res_gsh == res_taken);
   assign ch_upd     = res_valid && (bim_ok != gsh_ok);
   assign mispredict = res_valid && (res_pred != res_taken);

   tp_ctr_array #(.IDX_W(BIM_W), .INIT(CTR_WT)) u_bim (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(p_bim_idx), .rd_ctr(bim_ctr),
      .upd_en(res_valid), .upd_idx(r_bim_idx), .upd_up(res_taken));

   tp_ctr_array #(.IDX_W(HIST_W), .INIT(CTR_WT)) u_gsh (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(p_gsh_idx), .rd_ctr(gsh_ctr),
      .upd_en(res_valid), .upd_idx(r_gsh_idx), .upd_up(res_taken));

   tp_ctr_array #(.IDX_W(CH_W), .INIT(CTR_WNT)) u_chooser (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(p_ch_idx), .rd_ctr(ch_ctr),
      .upd_en(ch_upd), .upd_idx(r_ch_idx), .upd_up(bim_ok));

   tp_hist #(.HIST_W(HIST_W)) u_hist (
      .clk(clk), .rst_n(rst_n),
      .spec_en(pred_valid), .spec_dir(pred_taken),
      .fix_en(mispredict), .fix_ckpt(res_ckpt), .fix_dir(res_taken),
      .hist(hist));

   assign pred_bim   = bim_ctr[1];
   assign pred_gsh   = gsh_ctr[1];
   assign pred_taken = ch_ctr[1] ? pred_bim : pred_gsh;
   assign pred_ckpt  = hist;

   // R4: the final direction is always one of the two component opinions
   assert_pick_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_taken == pred_bim) || (pred_taken == pred_gsh));
endmodule

// File: tb/tb_tourn_predictor.sv
module tb_tourn_predictor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pred_valid = 1'b0;
   logic [31:0] pred_addr = '0;
   logic        pred_taken, pred_bim, pred_gsh;
   logic [11:0] pred_ckpt;
   logic        res_valid = 1'b0;
   logic [31:0] res_addr = '0;
   logic        res_taken = 1'b0;
   logic [11:0] res_ckpt = '0;
   logic        res_bim = 1'b0, res_gsh = 1'b0, res_pred = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [11:0] h = '0;

   always #10 clk = ~clk;

   tourn_predictor dut (
      .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_addr(pred_addr),
      .pred_taken(pred_taken), .pred_bim(pred_bim), .pred_gsh(pred_gsh),
      .pred_ckpt(pred_ckpt), .res_valid(res_valid), .res_addr(res_addr),
      .res_taken(res_taken), .res_ckpt(res_ckpt), .res_bim(res_bim),
      .res_gsh(res_gsh), .res_pred(res_pred));

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic peek(input logic [31:0] a);
      @(negedge clk);
      pred_addr  = a;
      pred_valid = 1'b0;
      #1;
   endtask

   task automatic predict(input logic [31:0] a, output logic dir, output logic [11:0] ck);
      @(negedge clk);
      pred_addr  = a;
      pred_valid = 1'b1;
      #1;
      dir = pred_taken;
      ck  = pred_ckpt;
      @(negedge clk);
      pred_valid = 1'b0;
   endtask

   task automatic resolve(input logic [31:0] a, input logic tk, input logic [11:0] ck,
                          input logic b, input logic g, input logic p);
      @(negedge clk);
      res_valid = 1'b1; res_addr = a; res_taken = tk; res_ckpt = ck;
      res_bim = b; res_gsh = g; res_pred = p;
      @(negedge clk);
      res_valid = 1'b0;
   endtask

   task automatic t_reset();
      peek(32'h0000_0123);
      check("R1", "pred_taken", pred_taken, 1);
      check("R1", "pred_bim", pred_bim, 1);
      check("R1", "pred_gsh", pred_gsh, 1);
      check("R1", "pred_ckpt", pred_ckpt, 0);
   endtask

   task automatic t_spec();
      logic d; logic [11:0] ck;
      predict(32'h40, d, ck);
      check("R5", "first ckpt", ck, h);
      h = {h[10:0], d};
      predict(32'h40, d, ck);
      check("R5", "second ckpt", ck, h);
      h = {h[10:0], d};
      for (int i = 0; i < 5; i++) begin
         predict(32'h40, d, ck);
         h = {h[10:0], d};
      end
      peek(32'h40);
      check("R5", "ckpt after shifts", pred_ckpt, h);
      check("R8", "bimodal untouched by predictions", pred_bim, 1);
   endtask

   task automatic t_hold();
      repeat (4) @(negedge clk);
      peek(32'h77);
      check("R9", "idle history", pred_ckpt, h);
   endtask

   task automatic t_restore();
      resolve(32'h300, 1'b0, 12'h0A5, 1'b1, 1'b1, 1'b1);
      h = 12'h14A;
      peek(32'h0);
      check("R6", "restored history", pred_ckpt, h);
      resolve(32'h301, 1'b1, 12'h000, 1'b1, 1'b1, 1'b1);
      peek(32'h0);
      check("R6", "correct resolve keeps history", pred_ckpt, h);
   endtask

   task automatic t_priority();
      @(negedge clk);
      pred_addr = 32'h50; pred_valid = 1'b1;
      res_valid = 1'b1; res_addr = 32'h310; res_taken = 1'b1; res_ckpt = 12'h055;
      res_bim = 1'b0; res_gsh = 1'b0; res_pred = 1'b0;
      @(negedge clk);
      pred_valid = 1'b0; res_valid = 1'b0;
      h = 12'h0AB;
      peek(32'h0);
      check("R7", "restore beats shift", pred_ckpt, h);
   endtask

   task automatic t_bimodal();
      for (int i = 0; i < 3; i++) resolve(32'h205, 1'b0, 12'h000, 1'b0, 1'b0, 1'b0);
      peek(32'h205);
      check("R3", "bimodal trained not-taken", pred_bim, 0);
      peek(32'h605);
      check("R2", "alias above bit 9 shares bimodal entry", pred_bim, 0);
      peek(32'h204);
      check("R2", "neighbour entry untouched", pred_bim, 1);
      resolve(32'h205, 1'b1, 12'h000, 1'b0, 1'b0, 1'b1);
      peek(32'h205);
      check("R3", "saturated at 00 then one up", pred_bim, 0);
      resolve(32'h205, 1'b1, 12'h000, 1'b0, 1'b0, 1'b1);
      peek(32'h205);
      check("R3", "two up reaches weakly taken", pred_bim, 1);
   endtask

   task automatic t_gshare();
      // train gshare entry 0x0F0 ^ 0x00F = 0x0FF down twice
      resolve(32'h00F, 1'b0, 12'h0F0, 1'b0, 1'b0, 1'b0);
      resolve(32'h00F, 1'b0, 12'h0F0, 1'b0, 1'b0, 1'b0);
      peek(32'h0);
      check("R8", "history unchanged by correct resolves", pred_ckpt, h);
      // mispredict to set the history to 0x0FF
      resolve(32'h3F0, 1'b1, 12'h07F, 1'b1, 1'b1, 1'b0);
      h = 12'h0FF;
      peek(32'h000);
      check("R2", "gshare index hist^addr hits trained entry", pred_gsh, 0);
      check("R4", "reset chooser picks gshare", pred_taken, 0);
      peek(32'h00F);
      check("R8", "training used checkpoint, not live history", pred_gsh, 1);
   endtask

   task automatic t_chooser();
      logic [31:0] q = 32'h1C3;
      resolve(q, 1'b0, 12'h000, 1'b0, 1'b0, 1'b0);
      resolve(q, 1'b0, 12'h000, 1'b0, 1'b0, 1'b0);
      peek(q);
      check("R4", "bimodal opinion", pred_bim, 0);
      check("R4", "chooser 01 selects gshare", pred_taken, 1);
      resolve(q, 1'b1, 12'h000, 1'b1, 1'b0, 1'b1);
      peek(q);
      check("R4", "bimodal right gshare wrong selects bimodal", pred_taken, 0);
      resolve(q, 1'b0, 12'h000, 1'b0, 1'b0, 1'b0);
      peek(q);
      check("R4", "both right leaves chooser", pred_taken, 0);
      resolve(q, 1'b1, 12'h000, 1'b0, 1'b1, 1'b1);
      peek(q);
      check("R4", "gshare right bimodal wrong selects gshare", pred_taken, 1);
      for (int i = 0; i < 3; i++) resolve(q, 1'b0, 12'h000, 1'b1, 1'b0, 1'b0);
      resolve(q, 1'b1, 12'h000, 1'b1, 1'b0, 1'b1);
      peek(q);
      check("R4", "chooser saturates at 00", pred_taken, 1);
      check("R3", "bimodal back to 01", pred_bim, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_spec();
      t_hold();
      t_restore();
      t_priority();
      t_bimodal();
      t_gshare();
      t_chooser();
      finish_run();
   end
endmodule